// File: doc/BRIEF.md
# Saturating CRC-Error Frame Counter Register

This block keeps a tally of received frames that the receive path marked as having a bad CRC. The receive logic raises a one-cycle event pulse for each such frame. The block adds one to a 16-bit tally for each pulse. Once the tally reaches its top value it stays there and does not wrap back to zero.

Software reaches the tally through a simple register bus. The bus has an address, a read strobe, a write strobe, 32-bit write data and 32-bit read data. The tally sits in the low half of a 32-bit word, and the upper half always reads as zero. Read data is registered and appears one cycle after the read strobe. The bus is plain control with no handshake, so every strobe is accepted in the cycle it is asserted.

A mode input selects how the tally is cleared. With the mode at 1, each read of the register returns the tally and then clears it. With the mode at 0, reads leave the tally alone, and only a write of one exact 32-bit pattern clears it.

Top module: `errcnt_stat_reg`

## Requirements
- R1: After reset the tally is zero, and the read data output is zero.
- R2: Each cycle with `err_pulse` high and no clear adds exactly one to the tally.
- R3: At 0xFFFF the tally holds its value when further `err_pulse` events arrive.
- R4: A read strobe at the register address is answered on the next cycle. `bus_rdata[15:0]` holds the tally as it stood before that cycle, and `bus_rdata[31:16]` is zero.
- R5: With `clr_on_rd` = 1, a read at the register address clears the tally after returning it.
- R6: With `clr_on_rd` = 0, reads do not change the tally.
- R7: With `clr_on_rd` = 0, a write of exactly 0x11111111 at the register address clears the tally.
- R8: With `clr_on_rd` = 0, a write of any other value leaves the tally unchanged. This includes every single-bit variation of 0x11111111.
- R9: With `clr_on_rd` = 1, writes of any value, including 0x11111111, leave the tally unchanged.
- R10: When a clearing access and an `err_pulse` fall in the same cycle, the tally becomes zero. The read in that cycle still returns the earlier tally.
- R11: An access whose `bus_addr` differs from `REG_ADDR` (default 0x00) does not change the tally, and such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_on_rd | input | 1 | Clear mode: 1 = clear on read, 0 = clear by writing the pattern |
| err_pulse | input | 1 | One-cycle event for each CRC-error frame |
| bus_addr | input | 8 | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after `bus_rd` |

## Verification
The hardest states to reach from the ports are the top of the range and the cycle where an event and a clear coincide.

The stimulus drives the tally to the edge of saturation with a long run of events. It then reads 0xFFFE, adds one event, and confirms that more events leave 0xFFFF unchanged.

For the clear rules, the bench first sweeps the write data through the pattern's 32 single-bit variants and several other near-miss values, showing that none of them clears the tally. It then lines up an event with a clearing read, and separately with a clearing write, in the same cycle.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;
  typedef enum logic {
    CLR_BY_PATTERN = 1'b0,
    CLR_BY_READ    = 1'b1
  } clr_mode_e;

  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_ADDR_W = 8;
endpackage

// File: rtl/errcnt_access_decode.sv
module errcnt_access_decode
  import errcnt_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter logic [DATA_W-1:0] CLR_PATTERN = 32'h1111_1111
) (
  input  logic              clr_on_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_any,
  output logic              rd_hit,
  output logic              clr_req
);
  clr_mode_e mode;
  logic      hit;
  logic      pattern_ok;

  always_comb begin
    mode       = clr_mode_e'(clr_on_rd);
    hit        = (bus_addr == REG_ADDR);
    pattern_ok = (bus_wdata == CLR_PATTERN);
    rd_any     = bus_rd;
    rd_hit     = bus_rd && hit;
    clr_req    = 1'b0;
    unique case (mode)
      CLR_BY_READ:    clr_req = hit && bus_rd;
      CLR_BY_PATTERN: clr_req = hit && bus_wr && pattern_ok;
      default:        clr_req = 1'b0;
    endcase
  end
endmodule

// File: rtl/errcnt_sat_counter.sv
module errcnt_sat_counter
  import errcnt_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic             at_max;

  assign at_max = (count_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clr) begin
      count_q <= '0;
    end else if (inc && !at_max) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/errcnt_rdata_reg.sv
module errcnt_rdata_reg
  import errcnt_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_any,
  input  logic              rd_hit,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] rdata_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {{PAD_W{1'b0}}, count};
    end else begin : g_nopad
      assign word = count[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_any) begin
      rdata_q <= rd_hit ? word : '0;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/errcnt_stat_reg.sv
module errcnt_stat_reg
  import errcnt_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter logic [DATA_W-1:0] CLR_PATTERN = 32'h1111_1111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_on_rd,
  input  logic              err_pulse,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic             rd_any;
  logic             rd_hit;
  logic             clr_req;
  logic [CNT_W-1:0] count_q;

  errcnt_access_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REG_ADDR(REG_ADDR), .CLR_PATTERN(CLR_PATTERN)
  ) u_dec (
    .clr_on_rd(clr_on_rd), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .rd_any(rd_any), .rd_hit(rd_hit), .clr_req(clr_req)
  );

  errcnt_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(err_pulse), .clr(clr_req), .count(count_q)
  );

  errcnt_rdata_reg #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_any(rd_any), .rd_hit(rd_hit),
    .count(count_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/errcnt_stat_reg_chk.sv
module errcnt_stat_reg_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter logic [DATA_W-1:0] CLR_PATTERN = 32'h1111_1111
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_on_rd,
  input logic              err_pulse,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  logic hit;
  logic quiet_wr;
  assign hit = (bus_addr == REG_ADDR);
  // No access that could clear the tally in this cycle
  assign quiet_wr = !(hit && ((clr_on_rd && bus_rd) ||
                     (!clr_on_rd && bus_wr && bus_wdata == CLR_PATTERN)));

  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_wr && err_pulse && count != MAXV) |=> count == CNT_W'($past(count) + 1'b1));

  assert_hold_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_wr && count == MAXV) |=> count == MAXV);

  assert_rd_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit) |=> bus_rdata == DATA_W'($past(count)));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:CNT_W] == '0);

  assert_clr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet_wr) |=> count == '0);

  assert_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_wr && !err_pulse) |=> $stable(count));
endmodule

bind errcnt_stat_reg errcnt_stat_reg_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .REG_ADDR(REG_ADDR), .CLR_PATTERN(CLR_PATTERN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_on_rd(clr_on_rd), .err_pulse(err_pulse),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(count_q)
);

// File: tb/errcnt_stat_reg_test.sv
module errcnt_stat_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_on_rd = 1'b0;
  logic        err_pulse = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  logic [31:0] got;

  localparam logic [31:0] PAT = 32'h1111_1111;

  always #10 clk = ~clk;

  errcnt_stat_reg uut (
    .clk(clk), .rst_n(rst_n), .clr_on_rd(clr_on_rd), .err_pulse(err_pulse),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access cycle; result sampled just after the edge that registers it
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0; bus_addr = 8'h00;
  endtask

  task automatic events(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); err_pulse = 1'b1;
    end
    @(negedge clk); err_pulse = 1'b0;
  endtask

  task automatic peek(input string req);   // non-clearing read in mode 0
    clr_on_rd = 1'b0;
    rd(8'h00, got);
    check(req, got, exp_cnt);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 rdata after reset", bus_rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    peek("R1 tally after reset");

    // R2 sweep of burst lengths
    for (int n = 1; n <= 12; n++) begin
      events(n);
      exp_cnt += n;
      peek("R2 increment");
      check("R4 upper half zero", {16'h0, got[31:16]}, 32'h0);
    end

    // R6 repeated reads leave tally unchanged
    for (int i = 0; i < 4; i++) peek("R6 read no clear");

    // R8 near misses do not clear
    for (int b = 0; b < 32; b++) begin
      wr(8'h00, PAT ^ (32'h1 << b));
      peek("R8 single-bit variant ignored");
    end
    wr(8'h00, 32'h0);          peek("R8 zero write ignored");
    wr(8'h00, 32'hFFFF_FFFF);  peek("R8 ones write ignored");
    // R11 pattern at another address
    wr(8'h04, PAT);            peek("R11 other address write ignored");
    rd(8'h04, got);            check("R11 other address read zero", got, 32'h0);
    peek("R11 tally kept");

    // R7 exact pattern clears
    wr(8'h00, PAT); exp_cnt = 0;
    peek("R7 pattern clears");

    // R9 mode 1 writes ignored
    events(7); exp_cnt = 7;
    clr_on_rd = 1'b1;
    wr(8'h00, PAT);
    wr(8'h00, 32'h0);
    peek("R9 mode1 writes ignored");

    // R5 clear on read
    clr_on_rd = 1'b1;
    rd(8'h00, got); check("R5 read returns tally", got, 32'd7);
    exp_cnt = 0;
    peek("R5 cleared after read");
    clr_on_rd = 1'b1;
    rd(8'h04, got); check("R11 mode1 other address read zero", got, 32'h0);
    exp_cnt = 0; events(3); exp_cnt = 3;
    clr_on_rd = 1'b1; rd(8'h04, got);
    peek("R11 mode1 other address no clear");

    // R10 event with clearing read
    events(2); exp_cnt = 5;
    clr_on_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b1; err_pulse = 1'b1;
    @(posedge clk); #1 got = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; err_pulse = 1'b0;
    check("R10 read returns old tally", got, 32'd5);
    exp_cnt = 0; peek("R10 clear beats event on read");

    // R10 event with clearing write
    events(4); exp_cnt = 4;
    clr_on_rd = 1'b0;
    @(negedge clk); bus_wr = 1'b1; bus_wdata = PAT; err_pulse = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0; err_pulse = 1'b0;
    exp_cnt = 0; peek("R10 clear beats event on write");

    // R3 saturation
    events(65534); exp_cnt = 65534;
    peek("R3 just below max");
    events(1); exp_cnt = 65535;
    peek("R3 reaches max");
    events(5);
    peek("R3 holds at max");
    check("R4 upper half zero at max", got, 32'h0000_FFFF);
    wr(8'h00, PAT); exp_cnt = 0;
    peek("R7 clear from max");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule